// File: doc/BRIEF.md
# Interrupt Source Recognition Unit

This unit sits beside the instruction sequencer of a processor core and decides, at every instruction boundary, whether an interrupt is to be taken and with which 8-bit vector. It watches two external request pins (one that cannot be masked, one gated by the interrupt-enable flag), the trap and overflow flags, and three status bits that decode reports for the instruction at the boundary: a divide overflow, the one-byte breakpoint opcode (CCh) and the overflow-check instruction. The chosen vector is handed to a dispatch sequencer as a single-cycle take pulse.

Events detected inside the core map to fixed vectors. For an external maskable request the unit runs an acknowledge handshake: it raises an acknowledge output for one cycle, reads the vector the interrupting device drives onto the data bus in the following cycle, and then issues the take pulse carrying that vector. The core is expected to hold off its next boundary strobe until the take pulse appears; strobes arriving during the handshake are dropped.

Top module: `intsrc_unit`

## Requirements
- R1: Out of reset, `take_o` and `ack_o` are low and `vec_o` is 0.
- R2: A boundary strobe with `div_ovf` set produces a take with vector 0 (a fault: the instruction restarts), winning over every other source present at that boundary.
- R3: With no fault, `brk_op` gives vector 3; otherwise `ovchk_op` gives vector 4 only when `of_flag` is 1, and is no event when `of_flag` is 0; both outrank single-step.
- R4: With no fault or software trap, a set `tf_flag` gives vector 1, outranking both external requests.
- R5: A rising edge on `nmi_pin`, sampled at least one clock before the boundary, is latched and gives vector 2 at the next boundary without a higher source, whatever `ie_flag` says; each edge is taken once, and a pin held high is not taken again.
- R6: `mreq_pin` is a level sampled only at a boundary strobe; it starts the acknowledge handshake only if `ie_flag` is 1 and no higher source is present; with `ie_flag` 0 there is no acknowledge and no take.
- R7: For an accepted maskable request, `ack_o` is high for exactly the one cycle after the boundary edge; `dbus_i` is captured at the end of the cycle after that, and `take_o` carries this captured value in the next cycle.
- R8: `take_o` is a one-cycle pulse that is never high together with `ack_o`; `vec_o` keeps the last vector between takes.
- R9: A boundary strobe arriving while the handshake is in its acknowledge or fetch cycle is ignored and leads to no extra take.
- R10: A boundary with no applicable source produces neither a take nor an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bnd_valid | input | 1 | Instruction boundary strobe, one cycle |
| div_ovf | input | 1 | Divide overflow detected in the instruction at this boundary |
| brk_op | input | 1 | Completed instruction was the breakpoint opcode CCh |
| ovchk_op | input | 1 | Completed instruction was the overflow-check instruction |
| of_flag | input | 1 | Overflow flag |
| tf_flag | input | 1 | Trap (single-step) flag |
| ie_flag | input | 1 | Interrupt-enable flag |
| nmi_pin | input | 1 | Non-maskable request, synchronous, edge sensitive |
| mreq_pin | input | 1 | Maskable request, level sensitive |
| dbus_i | input | 8 | Data bus carrying the device vector |
| ack_o | output | 1 | Interrupt acknowledge to the device |
| take_o | output | 1 | One-cycle pulse: take the interrupt in `vec_o` |
| vec_o | output | 8 | Vector of the interrupt being taken |

## Verification
A fixed-vector event taken at a boundary shows `take_o` one cycle after the edge that samples the strobe; a maskable request shows `ack_o` in that same slot, nothing in the next cycle, and `take_o` with the bus value two cycles after the acknowledge. The bench drives every input on the falling edge and samples outputs on later falling edges, counting exactly these register stages, and also samples the cycle after each take to confirm the pulse has ended. A rising edge on the non-maskable pin is always placed one full cycle before the boundary it is meant to reach, and the reference model clears its own pending bit only when it predicts vector 2.

// File: rtl/intsrc_pkg.sv
package intsrc_pkg;

    localparam int VEC_W = 8;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_FETCH = 2'd2
    } hs_state_e;

    typedef enum logic [2:0] {
        SRC_NONE  = 3'd0,
        SRC_FAULT = 3'd1,
        SRC_BRK   = 3'd2,
        SRC_OVCHK = 3'd3,
        SRC_STEP  = 3'd4,
        SRC_NMI   = 3'd5,
        SRC_EXT   = 3'd6
    } src_e;

    typedef struct packed {
        logic prev;
        logic pend;
    } nmi_reg_t;

    typedef struct packed {
        hs_state_e        st;
        logic             take;
        logic [VEC_W-1:0] vec;
    } hs_reg_t;

endpackage

// File: rtl/intsrc_nmi_latch.sv
module intsrc_nmi_latch
    import intsrc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic clr,
    output logic pend
);

    nmi_reg_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.prev = pin;
        // a new edge wins over a clear in the same cycle
        r_d.pend = (r_q.pend & ~clr) | (pin & ~r_q.prev);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.prev <= 1'b1;
            r_q.pend <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pend = r_q.pend;

endmodule

// File: rtl/intsrc_prio.sv
module intsrc_prio
    import intsrc_pkg::*;
#(
    parameter logic [VEC_W-1:0] VEC_DIV  = 8'd0,
    parameter logic [VEC_W-1:0] VEC_STEP = 8'd1,
    parameter logic [VEC_W-1:0] VEC_NMI  = 8'd2,
    parameter logic [VEC_W-1:0] VEC_BRK  = 8'd3,
    parameter logic [VEC_W-1:0] VEC_OVF  = 8'd4
) (
    input  logic             div_ovf,
    input  logic             brk_op,
    input  logic             ovchk_op,
    input  logic             of_flag,
    input  logic             tf_flag,
    input  logic             nmi_pend,
    input  logic             ie_flag,
    input  logic             mreq_pin,
    output src_e             src,
    output logic [VEC_W-1:0] fixed_vec
);

    always_comb begin
        src       = SRC_NONE;
        fixed_vec = '0;
        if (div_ovf) begin
            src       = SRC_FAULT;
            fixed_vec = VEC_DIV;
        end else if (brk_op) begin
            src       = SRC_BRK;
            fixed_vec = VEC_BRK;
        end else if (ovchk_op && of_flag) begin
            src       = SRC_OVCHK;
            fixed_vec = VEC_OVF;
        end else if (tf_flag) begin
            src       = SRC_STEP;
            fixed_vec = VEC_STEP;
        end else if (nmi_pend) begin
            src       = SRC_NMI;
            fixed_vec = VEC_NMI;
        end else if (ie_flag && mreq_pin) begin
            src       = SRC_EXT;
        end
    end

endmodule

// File: rtl/intsrc_hs_fsm.sv
module intsrc_hs_fsm
    import intsrc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bnd_valid,
    input  src_e             src,
    input  logic [VEC_W-1:0] fixed_vec,
    input  logic [VEC_W-1:0] dbus,
    output logic             ack,
    output logic             take,
    output logic [VEC_W-1:0] vec,
    output logic             nmi_clr,
    output logic             idle
);

    hs_reg_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.take = 1'b0;
        unique case (r_q.st)
            HS_IDLE: begin
                if (bnd_valid) begin
                    if (src == SRC_EXT) begin
                        r_d.st = HS_ACK;
                    end else if (src != SRC_NONE) begin
                        r_d.take = 1'b1;
                        r_d.vec  = fixed_vec;
                    end
                end
            end
            HS_ACK: begin
                r_d.st = HS_FETCH;
            end
            HS_FETCH: begin
                r_d.take = 1'b1;
                r_d.vec  = dbus;
                r_d.st   = HS_IDLE;
            end
            default: begin
                r_d.st = HS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= HS_IDLE;
            r_q.take <= 1'b0;
            r_q.vec  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign idle    = (r_q.st == HS_IDLE);
    assign ack     = (r_q.st == HS_ACK);
    assign take    = r_q.take;
    assign vec     = r_q.vec;
    assign nmi_clr = idle && bnd_valid && (src == SRC_NMI);

endmodule

// File: rtl/intsrc_unit.sv
module intsrc_unit
    import intsrc_pkg::*;
#(
    parameter logic [VEC_W-1:0] VEC_DIV  = 8'd0,
    parameter logic [VEC_W-1:0] VEC_STEP = 8'd1,
    parameter logic [VEC_W-1:0] VEC_NMI  = 8'd2,
    parameter logic [VEC_W-1:0] VEC_BRK  = 8'd3,
    parameter logic [VEC_W-1:0] VEC_OVF  = 8'd4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bnd_valid,
    input  logic             div_ovf,
    input  logic             brk_op,
    input  logic             ovchk_op,
    input  logic             of_flag,
    input  logic             tf_flag,
    input  logic             ie_flag,
    input  logic             nmi_pin,
    input  logic             mreq_pin,
    input  logic [VEC_W-1:0] dbus_i,
    output logic             ack_o,
    output logic             take_o,
    output logic [VEC_W-1:0] vec_o
);

    logic             nmi_pend;
    logic             nmi_clr;
    logic             hs_idle;
    src_e             sel_src;
    logic [VEC_W-1:0] sel_vec;

    intsrc_nmi_latch u_nmi (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (nmi_pin),
        .clr   (nmi_clr),
        .pend  (nmi_pend)
    );

    intsrc_prio #(
        .VEC_DIV  (VEC_DIV),
        .VEC_STEP (VEC_STEP),
        .VEC_NMI  (VEC_NMI),
        .VEC_BRK  (VEC_BRK),
        .VEC_OVF  (VEC_OVF)
    ) u_prio (
        .div_ovf   (div_ovf),
        .brk_op    (brk_op),
        .ovchk_op  (ovchk_op),
        .of_flag   (of_flag),
        .tf_flag   (tf_flag),
        .nmi_pend  (nmi_pend),
        .ie_flag   (ie_flag),
        .mreq_pin  (mreq_pin),
        .src       (sel_src),
        .fixed_vec (sel_vec)
    );

    intsrc_hs_fsm u_hs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bnd_valid (bnd_valid),
        .src       (sel_src),
        .fixed_vec (sel_vec),
        .dbus      (dbus_i),
        .ack       (ack_o),
        .take      (take_o),
        .vec       (vec_o),
        .nmi_clr   (nmi_clr),
        .idle      (hs_idle)
    );

endmodule

// File: rtl/intsrc_chk.sv
module intsrc_chk
    import intsrc_pkg::*;
#(
    parameter logic [VEC_W-1:0] DIV_V = 8'd0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bnd_valid,
    input logic             div_ovf,
    input logic             ie_flag,
    input logic             mreq_pin,
    input logic [VEC_W-1:0] dbus_i,
    input logic             ack_o,
    input logic             take_o,
    input logic [VEC_W-1:0] vec_o,
    input logic             idle,
    input logic             nmi_pend
);

    a_r2_fault_first: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_valid && idle && div_ovf) |=> (take_o && vec_o == DIV_V));

    a_r5_nmi_over_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_valid && idle && nmi_pend) |=> !ack_o);

    a_r6_ack_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(bnd_valid && ie_flag && mreq_pin));

    a_r7_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    a_r7_bus_vector: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ack_o, 2) |-> (take_o && vec_o == $past(dbus_i)));

    a_r8_take_not_ack: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !ack_o);

    a_r9_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_valid && ack_o) |=> (!take_o && !ack_o));

endmodule

bind intsrc_unit intsrc_chk #(.DIV_V(VEC_DIV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bnd_valid (bnd_valid),
    .div_ovf   (div_ovf),
    .ie_flag   (ie_flag),
    .mreq_pin  (mreq_pin),
    .dbus_i    (dbus_i),
    .ack_o     (ack_o),
    .take_o    (take_o),
    .vec_o     (vec_o),
    .idle      (hs_idle),
    .nmi_pend  (nmi_pend)
);

// File: tb/sim_intsrc_unit.sv
module sim_intsrc_unit;

    localparam int EXT  = 100;
    localparam int NONE = -1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bnd_valid = 1'b0;
    logic       div_ovf = 1'b0, brk_op = 1'b0, ovchk_op = 1'b0;
    logic       of_flag = 1'b0, tf_flag = 1'b0, ie_flag = 1'b0;
    logic       nmi_pin = 1'b0, mreq_pin = 1'b0;
    logic [7:0] dbus_i = 8'd0;
    logic       ack_o, take_o;
    logic [7:0] vec_o;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  m_nmi = 1'b0;
    int  last_vec = 0;

    always #10 clk = ~clk;

    intsrc_unit u0 (
        .clk(clk), .rst_n(rst_n), .bnd_valid(bnd_valid),
        .div_ovf(div_ovf), .brk_op(brk_op), .ovchk_op(ovchk_op),
        .of_flag(of_flag), .tf_flag(tf_flag), .ie_flag(ie_flag),
        .nmi_pin(nmi_pin), .mreq_pin(mreq_pin), .dbus_i(dbus_i),
        .ack_o(ack_o), .take_o(take_o), .vec_o(vec_o)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int ref_pick(bit dv, bit bk, bit oc, bit of, bit tf,
                                    bit np, bit ie, bit mr);
        if (dv) return 0;
        if (bk) return 3;
        if (oc && of) return 4;
        if (tf) return 1;
        if (np) return 2;
        if (ie && mr) return EXT;
        return NONE;
    endfunction

    function automatic string req_of(int e);
        case (e)
            0: return "R2 fault";
            3, 4: return "R3 trap";
            1: return "R4 step";
            2: return "R5 nmi";
            EXT: return "R6 mask";
            default: return "R10 none";
        endcase
    endfunction

    task automatic nmi_pulse();
        @(negedge clk); nmi_pin = 1'b1;
        @(negedge clk); nmi_pin = 1'b0;
        m_nmi = 1'b1;
    endtask

    task automatic do_bnd(bit dv, bit bk, bit oc, bit of, bit tf, bit ie, bit mr);
        int e;
        logic [7:0] d;
        @(negedge clk);
        div_ovf = dv; brk_op = bk; ovchk_op = oc; of_flag = of;
        tf_flag = tf; ie_flag = ie; mreq_pin = mr; bnd_valid = 1'b1;
        e = ref_pick(dv, bk, oc, of, tf, m_nmi, ie, mr);
        @(negedge clk);
        bnd_valid = 1'b0; div_ovf = 1'b0; brk_op = 1'b0; ovchk_op = 1'b0;
        mreq_pin = 1'b0;
        if (e == NONE) begin
            chk("R10 no take", int'(take_o), 0);
            chk("R10 no ack", int'(ack_o), 0);
            chk("R8 vec held", int'(vec_o), last_vec);
        end else if (e == EXT) begin
            chk("R7 ack cycle", int'(ack_o), 1);
            chk("R8 no take in ack", int'(take_o), 0);
            d = 8'($urandom);
            dbus_i = d;
            @(negedge clk);
            chk("R7 ack one cycle", int'(ack_o), 0);
            chk("R7 no take in fetch", int'(take_o), 0);
            @(negedge clk);
            dbus_i = 8'd0;
            chk("R7 take after fetch", int'(take_o), 1);
            chk("R7 bus vector", int'(vec_o), int'(d));
            last_vec = int'(d);
        end else begin
            chk({req_of(e), " take"}, int'(take_o), 1);
            chk({req_of(e), " vector"}, int'(vec_o), e);
            chk("R8 no ack with take", int'(ack_o), 0);
            last_vec = e;
            if (e == 2) m_nmi = 1'b0;
        end
        @(negedge clk);
        chk("R8 pulse ends", int'(take_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20871);
        repeat (3) @(negedge clk);
        chk("R1 take reset", int'(take_o), 0);
        chk("R1 ack reset", int'(ack_o), 0);
        chk("R1 vec reset", int'(vec_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed: each source alone
        do_bnd(1, 1, 1, 1, 1, 1, 1);   // R2 fault beats all
        do_bnd(0, 1, 1, 1, 1, 1, 1);   // R3 breakpoint
        do_bnd(0, 0, 1, 1, 1, 1, 1);   // R3 overflow check taken
        do_bnd(0, 0, 1, 0, 0, 0, 0);   // R3 overflow check, flag clear: nothing
        do_bnd(0, 0, 0, 0, 1, 1, 1);   // R4 step beats externals
        do_bnd(0, 0, 0, 0, 0, 1, 1);   // R6 maskable accepted
        do_bnd(0, 0, 0, 0, 0, 0, 1);   // R6 masked: nothing

        // R5 nmi with enable clear, and below step
        nmi_pulse();
        do_bnd(0, 0, 0, 0, 1, 0, 0);   // step wins, nmi stays pending
        do_bnd(0, 0, 0, 0, 0, 0, 1);   // R5 nmi taken with ie=0
        do_bnd(0, 0, 0, 0, 0, 0, 0);   // R5 taken once

        // R5 pin held high: one take only
        @(negedge clk); nmi_pin = 1'b1; m_nmi = 1'b1;
        do_bnd(0, 0, 0, 0, 0, 1, 1);
        do_bnd(0, 0, 0, 0, 0, 0, 0);
        nmi_pin = 1'b0;

        // R9 boundaries during acknowledge and fetch are dropped
        @(negedge clk);
        ie_flag = 1'b1; mreq_pin = 1'b1; bnd_valid = 1'b1;
        @(negedge clk);
        mreq_pin = 1'b0; div_ovf = 1'b1;
        chk("R9 ack started", int'(ack_o), 1);
        @(negedge clk);
        dbus_i = 8'h5A;
        chk("R9 no take from ack-cycle strobe", int'(take_o), 0);
        chk("R9 ack gone", int'(ack_o), 0);
        @(negedge clk);
        bnd_valid = 1'b0; div_ovf = 1'b0; dbus_i = 8'd0;
        chk("R9 bus vector taken", int'(vec_o), 8'h5A);
        chk("R9 take present", int'(take_o), 1);
        @(negedge clk);
        chk("R9 no take from fetch-cycle strobe", int'(take_o), 0);
        chk("R9 no ack after", int'(ack_o), 0);
        last_vec = 8'h5A;

        // constrained random
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(5) == 0) nmi_pulse();
            do_bnd($urandom_range(7) == 0, $urandom_range(5) == 0,
                   $urandom_range(4) == 0, $urandom_range(1) == 0,
                   $urandom_range(5) == 0, $urandom_range(1) == 0,
                   $urandom_range(1) == 0);
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule